// File: doc/BRIEF.md
# Half-Resolution Framebuffer with Doubled VGA Scan-Out

This block holds a picture of 320 columns by 240 rows and sends it to a 640x480 VGA monitor. It generates its own line and frame timing. During scan-out it draws every stored pixel as a square of two screen columns by two screen lines, so a quarter-size store fills the whole screen.

The store has two independent ports. The display side reads through one of them on every visible clock. The other port takes single-pixel writes from a drawing engine at any time, including during reset and during active video. A write never stalls the display and the display never blocks a write. Internally, several pixels share one storage word. A write updates only its own lane of that word.

Colour values pass through unchanged, at the width set by a parameter (4 bits by default). Mapping them to analog levels happens outside this block.

Top module: `pxfb_scanout`

## Requirements
- R1: While `rst_ni` is low, `hsync_o`=1, `vsync_o`=1, `blank_o`=1 and `pix_o`=0. Assertion takes effect at once, without a clock edge. After `rst_ni` rises, the beam position counters start advancing on the third rising clock edge.
- R2: A line is H_VIS+H_FP+H_SYNC+H_BP clocks long, where H_VIS = 2*IMG_W. A frame is V_VIS+V_FP+V_SYNC+V_BP lines, where V_VIS = 2*IMG_H. The defaults are 640+16+96+48 = 800 clocks per line and 480+10+2+33 = 525 lines per frame. Falling edges of `hsync_o` are one line apart, and falling edges of `vsync_o` are one frame apart.
- R3: `hsync_o` is 0 for exactly the columns h with H_VIS+H_FP <= h < H_VIS+H_FP+H_SYNC, and 1 otherwise. It appears two clocks after the counters reach that column.
- R4: `vsync_o` is 0 for every clock of the lines v with V_VIS+V_FP <= v < V_VIS+V_FP+V_SYNC, and 1 otherwise. It carries the same two-clock lag.
- R5: `blank_o` is 1 when h >= H_VIS or v >= V_VIS. On those clocks `pix_o` is 0. Both carry the same two-clock lag as the syncs.
- R6: At a visible position (h,v), `pix_o` shows the stored pixel with linear index (v/2)*IMG_W + h/2. Each stored pixel therefore fills a 2x2 block of screen pixels. The value appears two clocks after the counters reach (h,v).
- R7: On a rising clock edge with `wr_en_i`=1 and `wr_addr_i` < IMG_W*IMG_H, the stored pixel at linear index `wr_addr_i` becomes `wr_data_i`. Other pixels that share its storage word keep their values. Writes are accepted during reset and during active video.
- R8: If a write and the display read of the same pixel fall on the same clock edge, that scan shows the value from before the write. Later scans show the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Pixel write strobe |
| wr_addr_i | input | ADDR_W = clog2(IMG_W*IMG_H) | Linear pixel index, row*IMG_W + column |
| wr_data_i | input | PIX_W | Pixel value to store |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |
| blank_o | output | 1 | High outside the visible area |
| pix_o | output | PIX_W | Colour of the current screen pixel, zero while blanked |

## Verification
The bench follows the beam with its own counters and shadow picture, and compares every output on every clock. Several corner cases are checked this way:

- If the address has an off-by-one on the column or row halving, or if the row base steps on the wrong line, the picture shifts or shears, and the 2x2 block edges miscompare.
- If the sideband delay does not match the memory latency, the colour lands one column off from `blank_o` and the syncs.
- The bench deliberately writes each pixel on the same edge that the display reads it. A store that forwards the new data, or that writes the whole word instead of one lane, shows a wrong value in that scan or corrupts neighbouring pixels.
- A mid-line reset checks that the outputs drop asynchronously and that the scan restarts cleanly at the origin.

// File: rtl/pxfb_pkg.sv
package pxfb_pkg;

  // Beam sideband carried alongside the memory read
  typedef struct packed {
    logic hs;   // horizontal sync level, active low
    logic vs;   // vertical sync level, active low
    logic vis;  // beam inside the visible area
  } beam_t;

  localparam beam_t BEAM_IDLE = '{hs: 1'b1, vs: 1'b1, vis: 1'b0};

endpackage

// File: rtl/pxfb_rst_sync.sv
module pxfb_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] stage_q;
  logic [1:0] stage_n;

  always_comb begin
    stage_n = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_n;
    end
  end

  assign rst_no = stage_q[1];

endmodule

// File: rtl/pxfb_timing.sv
module pxfb_timing #(
  parameter int H_VIS   = 640,
  parameter int H_FP    = 16,
  parameter int H_SYNC  = 96,
  parameter int H_BP    = 48,
  parameter int V_VIS   = 480,
  parameter int V_FP    = 10,
  parameter int V_SYNC  = 2,
  parameter int V_BP    = 33,
  parameter int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP,
  parameter int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP,
  parameter int HC_W    = $clog2(H_TOTAL),
  parameter int VC_W    = $clog2(V_TOTAL)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [HC_W-1:0] h_o,
  output logic [VC_W-1:0] v_o,
  output logic            hs_o,
  output logic            vs_o,
  output logic            vis_o,
  output logic            line_end_o,
  output logic            frame_end_o
);

  localparam logic [HC_W-1:0] H_LAST  = HC_W'(H_TOTAL - 1);
  localparam logic [HC_W-1:0] H_VIS_L = HC_W'(H_VIS);
  localparam logic [HC_W-1:0] HS_BEG  = HC_W'(H_VIS + H_FP);
  localparam logic [HC_W-1:0] HS_END  = HC_W'(H_VIS + H_FP + H_SYNC);
  localparam logic [VC_W-1:0] V_LAST  = VC_W'(V_TOTAL - 1);
  localparam logic [VC_W-1:0] V_VIS_L = VC_W'(V_VIS);
  localparam logic [VC_W-1:0] VS_BEG  = VC_W'(V_VIS + V_FP);
  localparam logic [VC_W-1:0] VS_END  = VC_W'(V_VIS + V_FP + V_SYNC);

  logic [HC_W-1:0] h_q, h_n;
  logic [VC_W-1:0] v_q, v_n;
  logic            line_end, frame_end;

  assign line_end  = (h_q == H_LAST);
  assign frame_end = (v_q == V_LAST);

  always_comb begin
    h_n = h_q + HC_W'(1);
    v_n = v_q;
    if (line_end) begin
      h_n = '0;
      v_n = frame_end ? '0 : v_q + VC_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_n;
      v_q <= v_n;
    end
  end

  assign h_o         = h_q;
  assign v_o         = v_q;
  assign hs_o        = !((h_q >= HS_BEG) && (h_q < HS_END));
  assign vs_o        = !((v_q >= VS_BEG) && (v_q < VS_END));
  assign vis_o       = (h_q < H_VIS_L) && (v_q < V_VIS_L);
  assign line_end_o  = line_end;
  assign frame_end_o = frame_end;

  // R2: the column counter returns to zero right after the last column
  assert_hwrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_q == H_LAST) |=> (h_q == '0));

  // R2: the line counter only moves at a line boundary
  assert_vhold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_q != H_LAST) |=> $stable(v_q));

  // R4: vertical sync changes only when a new line begins
  assert_vs_linestart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_q != '0) |-> $stable(vs_o));

endmodule

// File: rtl/pxfb_fetch.sv
module pxfb_fetch #(
  parameter int IMG_W  = 320,
  parameter int V_VIS  = 480,
  parameter int HC_W   = 10,
  parameter int VC_W   = 10,
  parameter int ADDR_W = 17,
  parameter int LANE_W = 5,
  parameter int WORDS  = 2400,
  parameter int WA_W   = ADDR_W - LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HC_W-1:0]   h_i,
  input  logic [VC_W-1:0]   v_i,
  input  logic              vis_i,
  input  logic              line_end_i,
  input  logic              frame_end_i,
  output logic              rd_en_o,
  output logic [WA_W-1:0]   rd_word_o,
  output logic [LANE_W-1:0] rd_lane_o
);

  localparam int              BASE_W  = ADDR_W + 1;
  localparam logic [BASE_W-1:0] ROW_STEP = BASE_W'(IMG_W);
  localparam logic [VC_W-1:0]   V_VIS_L  = VC_W'(V_VIS);
  localparam logic [WA_W:0]     WORDS_L  = (WA_W+1)'(WORDS);

  // Linear index of the first stored pixel of the current source row
  logic [BASE_W-1:0] base_q, base_n;
  logic [ADDR_W-1:0] idx;

  always_comb begin
    base_n = base_q;
    if (line_end_i) begin
      if (frame_end_i) begin
        base_n = '0;
      end else if (v_i[0] && (v_i < V_VIS_L)) begin
        // leaving the second screen line of a source row
        base_n = base_q + ROW_STEP;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
    end else begin
      base_q <= base_n;
    end
  end

  assign idx       = base_q[ADDR_W-1:0] + ADDR_W'(h_i[HC_W-1:1]);
  assign rd_en_o   = vis_i;
  assign rd_word_o = idx[ADDR_W-1:LANE_W];
  assign rd_lane_o = idx[LANE_W-1:0];

  // R6: a visible read never addresses beyond the stored picture
  assert_word_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> ({1'b0, rd_word_o} < WORDS_L));

endmodule

// File: rtl/pxfb_store.sv
module pxfb_store #(
  parameter int PIX_W  = 4,
  parameter int LANES  = 32,
  parameter int WORDS  = 2400,
  parameter int WA_W   = 12,
  parameter int LANE_W = $clog2(LANES),
  parameter int WORD_W = PIX_W * LANES
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [WA_W-1:0]   wr_word_i,
  input  logic [LANE_W-1:0] wr_lane_i,
  input  logic [PIX_W-1:0]  wr_data_i,
  input  logic              rd_en_i,
  input  logic [WA_W-1:0]   rd_word_i,
  output logic [WORD_W-1:0] rd_data_o
);

  logic [WORD_W-1:0] mem [WORDS];
  logic [WORD_W-1:0] rd_q;

  // drawing port: one lane of one word per clock
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      mem[wr_word_i][wr_lane_i*PIX_W +: PIX_W] <= wr_data_i;
    end
  end

  // display port: registered read, returns the word as it was before this edge
  always_ff @(posedge clk_i) begin
    if (rd_en_i) begin
      rd_q <= mem[rd_word_i];
    end
  end

  assign rd_data_o = rd_q;

endmodule

// File: rtl/pxfb_scanout.sv
module pxfb_scanout #(
  parameter int PIX_W        = 4,
  parameter int IMG_W        = 320,
  parameter int IMG_H        = 240,
  parameter int H_FP         = 16,
  parameter int H_SYNC       = 96,
  parameter int H_BP         = 48,
  parameter int V_FP         = 10,
  parameter int V_SYNC       = 2,
  parameter int V_BP         = 33,
  parameter int PIX_PER_WORD = 32,
  parameter int ADDR_W       = $clog2(IMG_W * IMG_H)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [PIX_W-1:0]  wr_data_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              blank_o,
  output logic [PIX_W-1:0]  pix_o
);

  import pxfb_pkg::*;

  localparam int H_VIS   = 2 * IMG_W;
  localparam int V_VIS   = 2 * IMG_H;
  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HC_W    = $clog2(H_TOTAL);
  localparam int VC_W    = $clog2(V_TOTAL);
  localparam int NPIX    = IMG_W * IMG_H;
  localparam int LANE_W  = $clog2(PIX_PER_WORD);
  localparam int WORDS   = (NPIX + PIX_PER_WORD - 1) / PIX_PER_WORD;
  localparam int WA_W    = ADDR_W - LANE_W;
  localparam int WORD_W  = PIX_W * PIX_PER_WORD;
  localparam logic [ADDR_W:0] NPIX_L = (ADDR_W+1)'(NPIX);

  logic rst_s;

  pxfb_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_s)
  );

  logic [HC_W-1:0] tg_h;
  logic [VC_W-1:0] tg_v;
  logic            tg_hs, tg_vs, tg_vis, tg_line_end, tg_frame_end;

  pxfb_timing #(
    .H_VIS (H_VIS), .H_FP (H_FP), .H_SYNC (H_SYNC), .H_BP (H_BP),
    .V_VIS (V_VIS), .V_FP (V_FP), .V_SYNC (V_SYNC), .V_BP (V_BP)
  ) u_timing (
    .clk_i       (clk_i),
    .rst_ni      (rst_s),
    .h_o         (tg_h),
    .v_o         (tg_v),
    .hs_o        (tg_hs),
    .vs_o        (tg_vs),
    .vis_o       (tg_vis),
    .line_end_o  (tg_line_end),
    .frame_end_o (tg_frame_end)
  );

  logic              rd_en;
  logic [WA_W-1:0]   rd_word;
  logic [LANE_W-1:0] rd_lane;

  pxfb_fetch #(
    .IMG_W (IMG_W), .V_VIS (V_VIS), .HC_W (HC_W), .VC_W (VC_W),
    .ADDR_W (ADDR_W), .LANE_W (LANE_W), .WORDS (WORDS)
  ) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_s),
    .h_i         (tg_h),
    .v_i         (tg_v),
    .vis_i       (tg_vis),
    .line_end_i  (tg_line_end),
    .frame_end_i (tg_frame_end),
    .rd_en_o     (rd_en),
    .rd_word_o   (rd_word),
    .rd_lane_o   (rd_lane)
  );

  // writes beyond the picture are dropped
  logic wr_ok;
  assign wr_ok = wr_en_i && ({1'b0, wr_addr_i} < NPIX_L);

  logic [WORD_W-1:0] rd_data;

  pxfb_store #(
    .PIX_W (PIX_W), .LANES (PIX_PER_WORD), .WORDS (WORDS), .WA_W (WA_W)
  ) u_store (
    .clk_i     (clk_i),
    .wr_en_i   (wr_ok),
    .wr_word_i (wr_addr_i[ADDR_W-1:LANE_W]),
    .wr_lane_i (wr_addr_i[LANE_W-1:0]),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en),
    .rd_word_i (rd_word),
    .rd_data_o (rd_data)
  );

  // stage 1: sideband waits alongside the memory read
  beam_t             sb_n, sb_q;
  logic [LANE_W-1:0] lane_q;

  always_comb begin
    sb_n = '{hs: tg_hs, vs: tg_vs, vis: tg_vis};
  end

  always_ff @(posedge clk_i or negedge rst_s) begin
    if (!rst_s) begin
      sb_q   <= BEAM_IDLE;
      lane_q <= '0;
    end else begin
      sb_q   <= sb_n;
      lane_q <= rd_lane;
    end
  end

  // stage 2: lane select, blank gating, output registers
  logic [PIX_W-1:0] pix_n;

  always_comb begin
    pix_n = '0;
    if (sb_q.vis) begin
      pix_n = rd_data[lane_q*PIX_W +: PIX_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_s) begin
    if (!rst_s) begin
      hsync_o <= 1'b1;
      vsync_o <= 1'b1;
      blank_o <= 1'b1;
    end else begin
      hsync_o <= sb_q.hs;
      vsync_o <= sb_q.vs;
      blank_o <= !sb_q.vis;
    end
  end

  always_ff @(posedge clk_i or negedge rst_s) begin
    if (!rst_s) begin
      pix_o <= '0;
    end else begin
      pix_o <= pix_n;
    end
  end

  // R3: horizontal sync leaves the block two clocks after the timing unit
  assert_hs_lag_R3: assert property (@(posedge clk_i) disable iff (!rst_s)
    hsync_o == $past(tg_hs, 2));

  // R4: vertical sync keeps the same two-clock lag
  assert_vs_lag_R4: assert property (@(posedge clk_i) disable iff (!rst_s)
    vsync_o == $past(tg_vs, 2));

  // R5: no colour while blanked
  assert_blank_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_s)
    blank_o |-> (pix_o == '0));

endmodule

// File: tb/sim_pxfb_scanout.sv
`timescale 1ns/1ps
module sim_pxfb_scanout;

  localparam int IW = 16, IH = 12;
  localparam int HFP = 4, HSY = 8, HBP = 6;
  localparam int VFP = 3, VSY = 2, VBP = 4;
  localparam int HV = 2 * IW, VV = 2 * IH;
  localparam int HT = HV + HFP + HSY + HBP;
  localparam int VT = VV + VFP + VSY + VBP;
  localparam int NP = IW * IH;
  localparam int FRAME = HT * VT;
  localparam int AW = $clog2(NP);

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [3:0]    wr_data;
  logic          hsync, vsync, blank;
  logic [3:0]    pix;

  pxfb_scanout #(
    .PIX_W (4), .IMG_W (IW), .IMG_H (IH),
    .H_FP (HFP), .H_SYNC (HSY), .H_BP (HBP),
    .V_FP (VFP), .V_SYNC (VSY), .V_BP (VBP),
    .PIX_PER_WORD (4)
  ) u0 (
    .clk_i (clk), .rst_ni (rst_n),
    .wr_en_i (wr_en), .wr_addr_i (wr_addr), .wr_data_i (wr_data),
    .hsync_o (hsync), .vsync_o (vsync), .blank_o (blank), .pix_o (pix)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  bit cmp_en = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [3:0] mmem [NP];
  bit         rew  [NP];
  int    mh = 0, mv = 0, nrel = 0;
  bit    mid_hs = 1, mid_vs = 1, mid_bl = 1;
  int    mid_px = 0;
  string mid_tag = "R6";
  bit    out_hs = 1, out_vs = 1, out_bl = 1;
  int    out_px = 0;
  string out_tag = "R6";

  always @(posedge clk) begin
    if (rst_n !== 1'b1) begin
      nrel = 0; mh = 0; mv = 0;
      mid_hs = 1; mid_vs = 1; mid_bl = 1; mid_px = 0; mid_tag = "R6";
      out_hs = 1; out_vs = 1; out_bl = 1; out_px = 0; out_tag = "R6";
    end else begin
      nrel++;
      if (nrel >= 3) begin
        bit vis;
        int idx;
        out_hs = mid_hs; out_vs = mid_vs; out_bl = mid_bl;
        out_px = mid_px; out_tag = mid_tag;
        vis = (mh < HV) && (mv < VV);
        idx = (mv / 2) * IW + (mh / 2);
        mid_hs = !((mh >= HV + HFP) && (mh < HV + HFP + HSY));
        mid_vs = !((mv >= VV + VFP) && (mv < VV + VFP + VSY));
        mid_bl = !vis;
        mid_px = vis ? int'(mmem[idx]) : 0;
        if (vis && wr_en && int'(wr_addr) == idx) mid_tag = "R8";
        else if (vis && rew[idx])                 mid_tag = "R7";
        else                                      mid_tag = "R6";
        mh++;
        if (mh == HT) begin
          mh = 0;
          mv++;
          if (mv == VT) mv = 0;
        end
      end
    end
    if (wr_en && int'(wr_addr) < NP) begin
      mmem[wr_addr] = wr_data;
      if (rst_n === 1'b1) rew[wr_addr] = 1;
    end
  end

  // ---------------- per-clock comparison ----------------
  int cyc = 0;
  int last_hf = -1, last_vf = -1;
  bit prev_hs = 1, prev_vs = 1;

  always @(negedge clk) begin
    cyc++;
    if (rst_n !== 1'b1) begin
      last_hf = -1; last_vf = -1;
    end
    if (cmp_en) begin
      vectors++;
      chk("R3", "hsync", int'(hsync), int'(out_hs));
      chk("R4", "vsync", int'(vsync), int'(out_vs));
      chk("R5", "blank", int'(blank), int'(out_bl));
      chk(out_tag, "pix", int'(pix), out_px);
      if (prev_hs && !hsync) begin
        if (last_hf >= 0) begin
          vectors++;
          chk("R2", "hsync period", cyc - last_hf, HT);
        end
        last_hf = cyc;
      end
      if (prev_vs && !vsync) begin
        if (last_vf >= 0) begin
          vectors++;
          chk("R2", "vsync period", cyc - last_vf, FRAME);
        end
        last_vf = cyc;
      end
    end
    prev_hs = hsync;
    prev_vs = vsync;
  end

  task automatic check_reset_outputs();
    vectors++;
    chk("R1", "hsync in reset", int'(hsync), 1);
    chk("R1", "vsync in reset", int'(vsync), 1);
    chk("R1", "blank in reset", int'(blank), 1);
    chk("R1", "pix in reset", int'(pix), 0);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    check_reset_outputs();

    // R7: load the picture while reset is held
    for (int i = 0; i < NP; i++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = AW'(i);
      wr_data = 4'((i * 5 + 3) % 16);
    end
    @(negedge clk);
    wr_en = 1'b0;
    check_reset_outputs();

    cmp_en = 1;
    @(negedge clk);
    rst_n = 1'b1;
    // R2..R6: two frames of plain scan-out
    repeat (2 * FRAME + 10) @(negedge clk);

    // R7: scattered writes during live video
    for (int c = 0; c < FRAME; c++) begin
      wr_en = 1'b1;
      wr_addr = AW'((c * 37 + 11) % NP);
      wr_data = 4'((c * 3 + 1) % 16);
      @(negedge clk);
    end

    // R8: write each pixel on the very edge the display reads it
    for (int c = 0; c < FRAME; c++) begin
      if (mh < HV && mv < VV) begin
        int idx;
        idx = (mv / 2) * IW + (mh / 2);
        wr_en = 1'b1;
        wr_addr = AW'(idx);
        wr_data = ~mmem[idx];
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    // R8: the following frame shows the new values
    repeat (FRAME + 10) @(negedge clk);

    // R1: asynchronous reset in the middle of a line
    repeat (HT / 3) @(negedge clk);
    @(posedge clk);
    #2;
    cmp_en = 0;
    rst_n = 1'b0;
    #1;
    check_reset_outputs();
    @(posedge clk);
    @(negedge clk);
    cmp_en = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1, R2: clean restart from the origin
    repeat (FRAME + 20) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule